// File: doc/BRIEF.md
# General-Purpose Bidirectional Port

This block is a configurable-width general-purpose I/O port for a small controller. Each line can be an input or a push-pull output, selected by its own direction bit. Output values sit in a data latch that changes only when it is written. Pad levels enter through a two-flop synchronizer and are sampled into a read register when a read strobe arrives.

A read returns a mixed word. Input lines show their synchronized pad level, and output lines show their latch bit. The single-bit set, clear and toggle commands work on that mixed word and write the whole result back into the latch. As a result, a bit command also copies the present pad level of every input line into the latch.

A per-line wake mask selects which input lines raise a wake pulse when their synchronized level changes. A per-line pull-high configuration bit defines the level that an undriven pad presents.

Top module: `bidir_port`

## Requirements
- R1: After reset, every direction bit is 1 (all lines are inputs, so `pad_oe` is 0), the data latch holds all ones, the wake mask and pull configuration are 0, `wake` is 0 and `rd_data` is 0.
- R2: Command code 2 writes `cmd_data` into the direction register, where 1 means input and 0 means output. `pad_oe` equals the inverse of the direction register, so it changes in the cycle after the command and not in the cycle of the command.
- R3: Command code 1 writes `cmd_data` into the data latch, and `pad_out` always shows the latch. The latch keeps its value through any other command, including direction changes.
- R4: The read word holds the synchronized pad level at positions whose direction bit is 1 and the latch bit at positions whose direction bit is 0. Pad activity on output lines never appears in the read word.
- R5: A pad change reaches the read word through two synchronizer flops. `rd_en` high at a clock edge loads the read word into `rd_data`, and `rd_data` holds its value at all other edges. A pad change applied just before edge k is first seen by a read that is captured at edge k+2.
- R6: Command codes 5, 6 and 7 set, clear or toggle bit `cmd_bit` of the read word and write all WIDTH bits of the result into the data latch in one cycle.
- R7: Command code 3 writes the wake mask. `wake` is high for exactly one cycle, two edges after a pad change, when that change is on a line that is both masked and an input. Changes on unmasked lines or on output lines raise no pulse.
- R8: Command code 4 writes the pull configuration. A line with `pad_driven` low and its pull bit set presents 1. With the pull bit clear, or with `pad_driven` high, the line presents `pad_in`.
- R9: Command code 0, or `cmd_valid` low, changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Command code (0 none, 1 latch, 2 direction, 3 wake mask, 4 pull, 5 set, 6 clear, 7 toggle) |
| cmd_bit | input | IDX_W | Bit index for set, clear and toggle |
| cmd_data | input | WIDTH | Write data for full-word commands |
| rd_en | input | 1 | Read strobe |
| rd_data | output | WIDTH | Captured read word |
| pad_in | input | WIDTH | Pad levels seen from outside |
| pad_driven | input | WIDTH | 1 where something outside drives the pad |
| pad_out | output | WIDTH | Output drive value (data latch) |
| pad_oe | output | WIDTH | Output enable, 1 where the line is an output |
| wake | output | 1 | One-cycle wake pulse |

## Verification
The bench toggles bit 7 with a clear command while bit 7 is an input. A design that modifies only the latch, rather than the mixed read word, would drive the old latch bit and miss the pad level that should have been copied in. Synchronizer latency is measured read by read: a design with one flop too few or too many returns the new value one read early or late. The bench also checks that `pad_oe` does not move during the cycle of a direction write. Wake is exercised on an unmasked input, on a masked output and on a masked input; a design that ignores direction or mask pulses where it must stay quiet. Pull is checked on a floating pad and again with the pad driven low, which catches a design where the pull bit overrides a driven level.

// File: rtl/bidir_port_pkg.sv
package bidir_port_pkg;
  typedef enum logic [2:0] {
    OP_NOP      = 3'd0,
    OP_WR_LATCH = 3'd1,
    OP_WR_DIR   = 3'd2,
    OP_WR_WAKE  = 3'd3,
    OP_WR_PULL  = 3'd4,
    OP_BIT_SET  = 3'd5,
    OP_BIT_CLR  = 3'd6,
    OP_BIT_TOG  = 3'd7
  } port_op_e;
endpackage

// File: rtl/bp_sync.sv
module bp_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw,
  output logic [WIDTH-1:0] lvl,
  output logic [WIDTH-1:0] prev
);
  // Per line: two synchronizer stages plus one history stage for change detection.
  for (genvar i = 0; i < WIDTH; i++) begin : g_line
    logic s1, s2, s3;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= 1'b1;
        s2 <= 1'b1;
        s3 <= 1'b1;
      end else begin
        s1 <= raw[i];
        s2 <= s1;
        s3 <= s2;
      end
    end
    assign lvl[i]  = s2;
    assign prev[i] = s3;
  end
endmodule

// File: rtl/bp_regs.sv
module bp_regs import bidir_port_pkg::*; #(
  parameter int WIDTH = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  port_op_e         cmd_op,
  input  logic [IDX_W-1:0] cmd_bit,
  input  logic [WIDTH-1:0] cmd_data,
  input  logic [WIDTH-1:0] rd_mix,
  output logic [WIDTH-1:0] dir_q,
  output logic [WIDTH-1:0] latch_q,
  output logic [WIDTH-1:0] mask_q,
  output logic [WIDTH-1:0] pull_q
);
  function automatic logic [WIDTH-1:0] bit_edit(input logic [WIDTH-1:0] base,
                                                input logic [IDX_W-1:0] idx,
                                                input port_op_e op);
    logic [WIDTH-1:0] sel;
    sel = {{(WIDTH-1){1'b0}}, 1'b1} << idx;
    case (op)
      OP_BIT_SET: bit_edit = base | sel;
      OP_BIT_CLR: bit_edit = base & ~sel;
      default:    bit_edit = base ^ sel;
    endcase
  endfunction

  logic             rmw_hit;
  logic [WIDTH-1:0] rmw_word;

  assign rmw_hit  = cmd_valid && (cmd_op inside {OP_BIT_SET, OP_BIT_CLR, OP_BIT_TOG});
  assign rmw_word = bit_edit(rd_mix, cmd_bit, cmd_op);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '1;
      latch_q <= '1;
      mask_q  <= '0;
      pull_q  <= '0;
    end else if (rmw_hit) begin
      latch_q <= rmw_word;
    end else if (cmd_valid) begin
      case (cmd_op)
        OP_WR_LATCH: latch_q <= cmd_data;
        OP_WR_DIR:   dir_q   <= cmd_data;
        OP_WR_WAKE:  mask_q  <= cmd_data;
        OP_WR_PULL:  pull_q  <= cmd_data;
        default:     ;
      endcase
    end
  end
endmodule

// File: rtl/bp_view.sv
module bp_view #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] dir_q,
  input  logic [WIDTH-1:0] latch_q,
  input  logic [WIDTH-1:0] lvl,
  input  logic [WIDTH-1:0] prev,
  input  logic [WIDTH-1:0] mask_q,
  output logic [WIDTH-1:0] rd_mix,
  output logic             wake_any
);
  function automatic logic [WIDTH-1:0] mix_word(input logic [WIDTH-1:0] dir,
                                                input logic [WIDTH-1:0] pads,
                                                input logic [WIDTH-1:0] lat);
    mix_word = (dir & pads) | (~dir & lat);
  endfunction

  assign rd_mix   = mix_word(dir_q, lvl, latch_q);
  assign wake_any = |((lvl ^ prev) & mask_q & dir_q);
endmodule

// File: rtl/bidir_port.sv
module bidir_port import bidir_port_pkg::*; #(
  parameter int WIDTH = 8,
  localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_op,
  input  logic [IDX_W-1:0] cmd_bit,
  input  logic [WIDTH-1:0] cmd_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  input  logic [WIDTH-1:0] pad_in,
  input  logic [WIDTH-1:0] pad_driven,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_oe,
  output logic             wake
);
  function automatic logic [WIDTH-1:0] pad_level(input logic [WIDTH-1:0] pin,
                                                 input logic [WIDTH-1:0] drv,
                                                 input logic [WIDTH-1:0] pull);
    pad_level = pin | (~drv & pull);
  endfunction

  logic [WIDTH-1:0] dir_q, latch_q, mask_q, pull_q;
  logic [WIDTH-1:0] raw_lvl, sync_lvl, sync_prev, rd_mix;
  logic             wake_any;

  assign raw_lvl = pad_level(pad_in, pad_driven, pull_q);

  bp_sync #(.WIDTH(WIDTH)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw(raw_lvl), .lvl(sync_lvl), .prev(sync_prev)
  );

  bp_regs #(.WIDTH(WIDTH), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(port_op_e'(cmd_op)),
    .cmd_bit(cmd_bit), .cmd_data(cmd_data), .rd_mix(rd_mix),
    .dir_q(dir_q), .latch_q(latch_q), .mask_q(mask_q), .pull_q(pull_q)
  );

  bp_view #(.WIDTH(WIDTH)) u_view (
    .dir_q(dir_q), .latch_q(latch_q), .lvl(sync_lvl), .prev(sync_prev),
    .mask_q(mask_q), .rd_mix(rd_mix), .wake_any(wake_any)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_mix;
  end

  assign pad_out = latch_q;
  assign pad_oe  = ~dir_q;
  assign wake    = wake_any;
endmodule

// File: rtl/bidir_port_chk.sv
module bidir_port_chk #(
  parameter int WIDTH = 8,
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic [2:0]       cmd_op,
  input logic [IDX_W-1:0] cmd_bit,
  input logic [WIDTH-1:0] cmd_data,
  input logic             rd_en,
  input logic [WIDTH-1:0] rd_data,
  input logic [WIDTH-1:0] pad_out,
  input logic [WIDTH-1:0] pad_oe,
  input logic             wake,
  input logic [WIDTH-1:0] mask_q,
  input logic [WIDTH-1:0] dir_q
);
  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  // R2
  oe_after_dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd2) |=> (pad_oe == ~$past(cmd_data)));

  // R3
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && (cmd_op == 3'd1 || cmd_op >= 3'd5)) |=> $stable(pad_out));

  // R6
  bit_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd5) |=> (((pad_out >> $past(cmd_bit)) & ONE) == ONE));

  // R6
  bit_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd6) |=> (((pad_out >> $past(cmd_bit)) & ONE) == '0));

  // R5
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

  // R7
  no_wake_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mask_q & dir_q) == '0) |-> !wake);
endmodule

bind bidir_port bidir_port_chk #(.WIDTH(WIDTH), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_bit(cmd_bit),
  .cmd_data(cmd_data), .rd_en(rd_en), .rd_data(rd_data), .pad_out(pad_out),
  .pad_oe(pad_oe), .wake(wake), .mask_q(mask_q), .dir_q(dir_q)
);

// File: tb/bidir_port_test.sv
module bidir_port_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic [2:0] cmd_bit = 3'd0;
  logic [7:0] cmd_data = 8'h00;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic [7:0] pad_in = 8'hFF;
  logic [7:0] pad_driven = 8'hFF;
  logic [7:0] pad_out, pad_oe;
  logic       wake;

  int errors = 0;
  int checks = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rd_pend_q = 1'b0;
  int         cycles = 0;

  always #10 clk = ~clk;

  bidir_port uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_bit(cmd_bit),
    .cmd_data(cmd_data), .rd_en(rd_en), .rd_data(rd_data), .pad_in(pad_in),
    .pad_driven(pad_driven), .pad_out(pad_out), .pad_oe(pad_oe), .wake(wake)
  );

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver tasks start and end at a falling edge.
  task automatic issue(input logic [2:0] op, input logic [2:0] b, input logic [7:0] d);
    cmd_valid = 1'b1; cmd_op = op; cmd_bit = b; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 3'd0;
  endtask

  task automatic rd(input logic [7:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: compare each captured read against the scoreboard.
  always @(posedge clk) rd_pend_q <= rd_en;
  always @(negedge clk) begin
    if (rd_pend_q) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R5: actual=%h expected=<no pending read>", rd_data);
      end else begin
        check(tag_q.pop_front(), rd_data, exp_q.pop_front());
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d expected<20000 cycles", cycles);
      finish_run();
    end
  end

  initial begin
    idle(3);
    // R1 reset state
    check("R1 pad_oe", pad_oe, 8'h00);
    check("R1 pad_out", pad_out, 8'hFF);
    check("R1 wake", {7'd0, wake}, 8'h00);
    check("R1 rd_data", rd_data, 8'h00);
    rst_n = 1'b1;
    idle(2);
    rd(8'hFF, "R1 read all inputs");

    // R2: direction takes effect the next cycle
    cmd_valid = 1'b1; cmd_op = 3'd2; cmd_data = 8'hF0;
    #1 check("R2 oe before edge", pad_oe, 8'h00);
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 3'd0;
    check("R2 oe after edge", pad_oe, 8'h0F);

    // R3 latch write
    issue(3'd1, 3'd0, 8'hA5);
    check("R3 pad_out", pad_out, 8'hA5);

    // R4 mixed read
    pad_in = 8'h3C; idle(2);
    rd(8'h35, "R4 mixed read");
    pad_in = 8'h3A; idle(3);
    rd(8'h35, "R4 output pads hidden");

    // R5 synchronizer latency
    pad_in = 8'hCA;
    rd(8'h35, "R5 edge k");
    rd(8'h35, "R5 edge k+1");
    rd(8'hC5, "R5 edge k+2");

    // R6 read-modify-write
    issue(3'd5, 3'd1, 8'h00);
    check("R6 set bit1", pad_out, 8'hC7);
    issue(3'd6, 3'd7, 8'h00);
    check("R6 clear input bit7", pad_out, 8'h47);
    rd(8'hC7, "R6 read after clear");
    issue(3'd7, 3'd0, 8'h00);
    check("R6 toggle bit0", pad_out, 8'hC6);

    // R9 no-op command
    issue(3'd0, 3'd2, 8'h00);
    check("R9 nop latch", pad_out, 8'hC6);
    check("R9 nop oe", pad_oe, 8'h0F);

    // R3 latch held across direction changes
    issue(3'd2, 3'd0, 8'hFF);
    check("R3 oe all inputs", pad_oe, 8'h00);
    issue(3'd2, 3'd0, 8'hF0);
    check("R3 latch kept", pad_out, 8'hC6);

    // R7 wake
    issue(3'd3, 3'd0, 8'h11);
    pad_in = 8'hEA;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); check("R7 unmasked line", {7'd0, wake}, 8'h00);
    end
    pad_in = 8'hEB;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); check("R7 masked output line", {7'd0, wake}, 8'h00);
    end
    pad_in = 8'hFB;
    @(negedge clk); check("R7 wake edge k+1", {7'd0, wake}, 8'h00);
    @(negedge clk); check("R7 wake edge k+2", {7'd0, wake}, 8'h01);
    @(negedge clk); check("R7 wake edge k+3", {7'd0, wake}, 8'h00);

    // R8 pull-high
    pad_driven = 8'hBF; pad_in = 8'hBB; idle(3);
    rd(8'hB6, "R8 floating no pull");
    issue(3'd4, 3'd0, 8'h40); idle(3);
    rd(8'hF6, "R8 floating with pull");
    pad_driven = 8'hFF; idle(3);
    rd(8'hB6, "R8 driven low overrides pull");

    idle(3);
    check("R5 scoreboard drained", 8'(exp_q.size()), 8'h00);
    finish_run();
  end
endmodule